// File: doc/BRIEF.md
# Buffered I2C Slave Receive Engine

This block listens on an I2C bus as a slave receiver. It watches SCL and SDA for a START condition, shifts in a 7-bit address and the direction bit, and acknowledges when the address is its own with a write direction, or when it is the General Call address 00h and General Call response is enabled. After an accepted address it collects a run of data bytes into a small internal buffer without host help. It acknowledges each byte and raises its interrupt flag only when the programmed run length is reached, or earlier when the master ends the transfer.

A host processor reaches four registers through a simple write port and a registered read port, selected by a 2-bit code: 0 = address, 1 = control, 2 = byte count, 3 = status (read-only). Received bytes are read through a separate registered buffer port. While the interrupt flag is pending during a transfer, the block holds SCL low. The host releases the bus by writing the control register with the flag bit at 0.

Top module: `i2c_bufrx`

## Requirements
- R1: After reset, irq_n is 1, scl_oe and sda_oe are 0, the control register reads 00h and the status register reads F8h.
- R2: With control bits enable (bit 6) = 1, acknowledge-enable (bit 7) = 1, start request (bit 5) = 0, stop request (bit 4) = 0 and the flag (bit 3) clear, an address byte whose upper 7 bits equal address-register bits 7:1 and whose bit 0 is 0 is acknowledged. The flag is then set, irq_n goes low and status reads 60h.
- R3: Address byte 00h is acknowledged only when address-register bit 0 is 1, under the same control conditions as R2, and then sets the flag with status D0h.
- R4: Any other address byte, a read direction (bit 0 = 1), enable = 0, acknowledge-enable = 0 or a start/stop request bit at 1 gives a NACK and leaves the flag clear.
- R5: After an accepted address, data bytes are stored in the buffer from index 0 upward in arrival order. The flag stays clear until the run length is reached, then is set with status 80h (own address) or 90h (General Call). Count-register reads return bit 7 of the written count and, in bits 6:0, the number of bytes stored in the current run.
- R6: With control bit 0 (mode) = 0, the run length is 1 byte regardless of the count register.
- R7: The final byte of a run is answered with NACK when count bit 7 is 1 or acknowledge-enable is 0 at that byte. Status is then 88h (own) or 98h (General Call), and later bytes get no ACK, are not stored and set no flag until the next START.
- R8: While the flag is set during an address-acknowledged transfer, SCL is held low (scl_oe = 1). A control write with bit 3 = 0 clears the flag and releases SCL. A control write with bit 3 = 1 never sets the flag.
- R9: A STOP or repeated START while receiving data with the flag clear sets the flag with status A0h, and the block then recognises a new address.
- R10: A count field (bits 6:0) of 0 or above 68 gives a run length of 68, so no more than 68 bytes are stored per run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Write register select (0 address, 1 control, 2 count) |
| reg_wdata | input | 8 | Register write data |
| rd_sel | input | 2 | Read register select (0 address, 1 control, 2 count, 3 status) |
| rd_data | output | 8 | Registered read data, valid the cycle after rd_sel |
| buf_raddr | input | AW | Buffer read index |
| buf_rdata | output | 8 | Registered buffer byte at buf_raddr |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Drive SCL low when 1 |
| sda_oe | output | 1 | Drive SDA low when 1 |
| irq_n | output | 1 | Active-low interrupt, low while the flag is set |

## Verification
The checker watches on every cycle that SCL is never stretched without a pending flag, that a stretch lasts until the host clears the flag, that SDA is never pulled low while SCL is held, that every falling edge of the interrupt comes with a legal status code, and that no buffer write goes past the last entry. Address matching, the ordering of bytes in the buffer, the moment the flag rises within a run, the NACK rules for the final byte, the ignored bytes after a NACK, the effect of early STOP and repeated START, and the run length clamp can only be shown by the bench's bus scenarios.

// File: rtl/i2c_bufrx_pkg.sv
package i2c_bufrx_pkg;
  localparam logic [7:0] ST_IDLE      = 8'hF8;
  localparam logic [7:0] ST_OWN_ADDR  = 8'h60;
  localparam logic [7:0] ST_GC_ADDR   = 8'hD0;
  localparam logic [7:0] ST_OWN_ACK   = 8'h80;
  localparam logic [7:0] ST_OWN_NACK  = 8'h88;
  localparam logic [7:0] ST_GC_ACK    = 8'h90;
  localparam logic [7:0] ST_GC_NACK   = 8'h98;
  localparam logic [7:0] ST_ENDED     = 8'hA0;

  localparam logic [1:0] SEL_ADR = 2'd0;
  localparam logic [1:0] SEL_CTL = 2'd1;
  localparam logic [1:0] SEL_CNT = 2'd2;
  localparam logic [1:0] SEL_STA = 2'd3;

  localparam int CB_ACKEN = 7;
  localparam int CB_EN    = 6;
  localparam int CB_STREQ = 5;
  localparam int CB_SPREQ = 4;
  localparam int CB_FLAG  = 3;
  localparam int CB_MODE  = 0;

  typedef enum logic [2:0] {
    B_IDLE, B_ADDR, B_AACK, B_DATA, B_DACK, B_SKIP
  } bus_st_e;
endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_lvl
);
  logic [SYNC:0] scl_sh, sda_sh;
  logic scl_c, scl_p, sda_c, sda_p;

  assign scl_c = scl_sh[SYNC-1];
  assign scl_p = scl_sh[SYNC];
  assign sda_c = sda_sh[SYNC-1];
  assign sda_p = sda_sh[SYNC];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh    <= '1;
      sda_sh    <= '1;
      scl_rise  <= 1'b0;
      scl_fall  <= 1'b0;
      start_det <= 1'b0;
      stop_det  <= 1'b0;
      sda_lvl   <= 1'b1;
    end else begin
      scl_sh    <= {scl_sh[SYNC-1:0], scl_i};
      sda_sh    <= {sda_sh[SYNC-1:0], sda_i};
      scl_rise  <= scl_c & ~scl_p;
      scl_fall  <= ~scl_c & scl_p;
      start_det <= scl_c & scl_p & sda_p & ~sda_c;
      stop_det  <= scl_c & scl_p & ~sda_p & sda_c;
      sda_lvl   <= sda_c;
    end
  end
endmodule

// File: rtl/i2c_byte_mem.sv
module i2c_byte_mem #(
  parameter int W     = 8,
  parameter int DEPTH = 68,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2c_bufrx.sv
module i2c_bufrx
  import i2c_bufrx_pkg::*;
#(
  parameter int DEPTH = 68,
  parameter int SYNC  = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [7:0]    reg_wdata,
  input  logic [1:0]    rd_sel,
  output logic [7:0]    rd_data,
  input  logic [AW-1:0] buf_raddr,
  output logic [7:0]    buf_rdata,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          irq_n
);
  localparam logic [6:0]    DEPTH7   = 7'(DEPTH);
  localparam logic [AW-1:0] DEPTH_AW = AW'(DEPTH);
  localparam logic [AW-1:0] ONE_AW   = AW'(1);

  logic scl_rise, scl_fall, start_det, stop_det, sda_lvl;
  logic [7:0] adr_q, ctl_q, cnt_q, stat_q;
  logic si_q;
  bus_st_e st;
  logic [2:0] bit_cnt;
  logic [7:0] shreg;
  logic [AW-1:0] idx, run_len, widx;
  logic wrap, is_gc, match_q, nack_q, final_q, ack_ph;
  logic mem_we;
  logic [AW-1:0] mem_waddr;
  logic [7:0] mem_wdata;
  logic [7:0] rx_byte;
  logic addressed, may_ack, own_hit, gc_hit, is_final;

  i2c_line_mon #(.SYNC(SYNC)) u_mon (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_lvl(sda_lvl)
  );

  i2c_byte_mem #(.W(8), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(buf_raddr), .rdata(buf_rdata)
  );

  // Run length: byte mode gives one byte, out-of-range counts clamp to depth
  always_comb begin
    if (!ctl_q[CB_MODE])
      run_len = ONE_AW;
    else if (cnt_q[6:0] == 7'd0 || cnt_q[6:0] > DEPTH7)
      run_len = DEPTH_AW;
    else
      run_len = AW'(cnt_q[6:0]);
  end

  assign rx_byte   = {shreg[6:0], sda_lvl};
  assign addressed = (st == B_DATA) || (st == B_DACK);
  assign may_ack   = ctl_q[CB_EN] & ctl_q[CB_ACKEN] & ~ctl_q[CB_STREQ]
                   & ~ctl_q[CB_SPREQ] & ~si_q;
  assign own_hit   = (rx_byte[7:1] == adr_q[7:1]) & ~rx_byte[0];
  assign gc_hit    = (rx_byte == 8'h00) & adr_q[0];
  assign widx      = wrap ? '0 : idx;
  assign is_final  = (widx + ONE_AW) == run_len;

  always_ff @(posedge clk) begin
    mem_we <= 1'b0;
    if (rst) begin
      adr_q   <= 8'h00;
      ctl_q   <= 8'h00;
      cnt_q   <= 8'h00;
      stat_q  <= ST_IDLE;
      si_q    <= 1'b0;
      st      <= B_IDLE;
      bit_cnt <= 3'd0;
      shreg   <= 8'h00;
      idx     <= '0;
      wrap    <= 1'b0;
      is_gc   <= 1'b0;
      match_q <= 1'b0;
      nack_q  <= 1'b0;
      final_q <= 1'b0;
      ack_ph  <= 1'b0;
      sda_oe  <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= 8'h00;
    end else begin
      if (reg_we) begin
        case (reg_sel)
          SEL_ADR: adr_q <= reg_wdata;
          SEL_CTL: begin
            ctl_q <= {reg_wdata[7:4], 3'b000, reg_wdata[0]};
            if (!reg_wdata[CB_FLAG]) si_q <= 1'b0;
          end
          SEL_CNT: cnt_q <= reg_wdata;
          default: ;
        endcase
      end
      if (start_det || stop_det) begin
        if (addressed && !si_q) begin
          si_q   <= 1'b1;
          stat_q <= ST_ENDED;
        end
        st      <= start_det ? B_ADDR : B_IDLE;
        bit_cnt <= 3'd0;
        ack_ph  <= 1'b0;
        sda_oe  <= 1'b0;
      end else begin
        case (st)
          B_ADDR: if (scl_rise) begin
            shreg   <= rx_byte;
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              match_q <= may_ack & (own_hit | gc_hit);
              is_gc   <= gc_hit;
              st      <= B_AACK;
            end
          end
          B_AACK: if (scl_fall) begin
            if (!ack_ph) begin
              ack_ph <= 1'b1;
              sda_oe <= match_q;
              if (!match_q) st <= B_SKIP;
            end else begin
              ack_ph  <= 1'b0;
              sda_oe  <= 1'b0;
              si_q    <= 1'b1;
              stat_q  <= is_gc ? ST_GC_ADDR : ST_OWN_ADDR;
              idx     <= '0;
              wrap    <= 1'b0;
              bit_cnt <= 3'd0;
              st      <= B_DATA;
            end
          end
          B_DATA: if (scl_rise) begin
            shreg   <= rx_byte;
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              mem_we    <= 1'b1;
              mem_waddr <= widx;
              mem_wdata <= rx_byte;
              idx       <= widx + ONE_AW;
              wrap      <= 1'b0;
              final_q   <= is_final;
              nack_q    <= is_final & (~ctl_q[CB_ACKEN] | cnt_q[7]);
              st        <= B_DACK;
            end
          end
          B_DACK: if (scl_fall) begin
            if (!ack_ph) begin
              ack_ph <= 1'b1;
              sda_oe <= ~nack_q;
            end else begin
              ack_ph  <= 1'b0;
              sda_oe  <= 1'b0;
              bit_cnt <= 3'd0;
              st      <= nack_q ? B_SKIP : B_DATA;
              if (final_q) begin
                si_q <= 1'b1;
                wrap <= 1'b1;
                case ({is_gc, nack_q})
                  2'b00:   stat_q <= ST_OWN_ACK;
                  2'b01:   stat_q <= ST_OWN_NACK;
                  2'b10:   stat_q <= ST_GC_ACK;
                  default: stat_q <= ST_GC_NACK;
                endcase
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // Registered outputs: interrupt, clock stretch and register read
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n   <= 1'b1;
      scl_oe  <= 1'b0;
      rd_data <= 8'h00;
    end else begin
      irq_n  <= ~si_q;
      scl_oe <= si_q & (st != B_IDLE) & (st != B_SKIP);
      case (rd_sel)
        SEL_ADR: rd_data <= adr_q;
        SEL_CTL: rd_data <= ctl_q | {4'b0000, si_q, 3'b000};
        SEL_CNT: rd_data <= {cnt_q[7], 7'(idx)};
        default: rd_data <= stat_q;
      endcase
    end
  end
endmodule

// File: rtl/i2c_bufrx_chk.sv
module i2c_bufrx_chk #(
  parameter int DEPTH = 68,
  parameter int AW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst,
  input logic          irq_n,
  input logic          scl_oe,
  input logic          sda_oe,
  input logic [7:0]    stat_q,
  input logic          mem_we,
  input logic [AW-1:0] mem_waddr
);
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (irq_n && !scl_oe && !sda_oe));

  a_r8_no_stretch_without_flag: assert property (@(posedge clk) disable iff (rst)
    scl_oe |-> !irq_n);

  a_r8_hold_until_clear: assert property (@(posedge clk) disable iff (rst)
    (scl_oe && !irq_n) |=> (scl_oe || irq_n));

  a_r7_no_ack_while_stretch: assert property (@(posedge clk) disable iff (rst)
    !(sda_oe && scl_oe));

  a_r2_legal_status: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> (stat_q inside {8'h60, 8'hD0, 8'h80, 8'h88,
                                     8'h90, 8'h98, 8'hA0}));

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (32'(mem_waddr) < DEPTH));
endmodule

bind i2c_bufrx i2c_bufrx_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .irq_n(irq_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .stat_q(stat_q), .mem_we(mem_we), .mem_waddr(mem_waddr)
);

// File: tb/test_i2c_bufrx.sv
module test_i2c_bufrx;
  localparam int Q  = 10;
  localparam int AW = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [1:0] rd_sel = 2'd0;
  logic [7:0] rd_data;
  logic [AW-1:0] buf_raddr = '0;
  logic [7:0] buf_rdata;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe, irq_n;
  logic scl_line, sda_line;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2c_bufrx i_i2c_bufrx (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
    .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
    .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq_n(irq_n)
  );

  // {address reg, address byte, expect ack, expect status}
  localparam logic [24:0] VEC [6] = '{
    {8'hAA, 8'hAA, 1'b1, 8'h60},
    {8'hAA, 8'hAB, 1'b0, 8'h00},
    {8'hAA, 8'hA8, 1'b0, 8'h00},
    {8'hAB, 8'h00, 1'b1, 8'hD0},
    {8'hAA, 8'h00, 1'b0, 8'h00},
    {8'hFE, 8'hFE, 1'b1, 8'h60}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic reg_read(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk); rd_sel = sel;
    @(negedge clk); @(negedge clk);
    d = rd_data;
  endtask

  task automatic buf_read(input int a, output logic [7:0] d);
    @(negedge clk); buf_raddr = AW'(a);
    @(negedge clk); @(negedge clk);
    d = buf_rdata;
  endtask

  task automatic wait_high;
    while (!scl_line) @(posedge clk);
  endtask

  task automatic i2c_start;
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_rstart;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; wait_high; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; wait_high; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic i2c_bit(input logic b, output logic r);
    sda_m = b; tick(Q); scl_m = 1'b1; wait_high; tick(Q);
    r = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) i2c_bit(b[i], r);
    i2c_bit(1'b1, r);
    ack = ~r;
    @(negedge clk);
  endtask

  task automatic clear_flag(input logic [7:0] ctl);
    reg_write(2'd1, ctl & 8'hF7);
  endtask

  task automatic open_own(input logic [7:0] cnt);
    logic a;
    logic [7:0] d;
    reg_write(2'd2, cnt);
    i2c_start;
    i2c_byte(8'hAA, a);
    chk("R2 open ack", {7'd0, a}, 8'h01);
    reg_read(2'd3, d);
    chk("R2 open status", d, 8'h60);
    clear_flag(8'hC1);
  endtask

  task automatic stop_ended;
    logic [7:0] d;
    i2c_stop; tick(4);
    @(negedge clk);
    chk("R9 stop irq", {7'd0, irq_n}, 8'h00);
    reg_read(2'd3, d);
    chk("R9 stop status", d, 8'hA0);
    clear_flag(8'hC1);
  endtask

  task automatic clamp_run(input logic [7:0] cnt);
    logic a;
    logic [7:0] d;
    int early = 0;
    open_own(cnt);
    for (int i = 0; i < 67; i++) begin
      i2c_byte(8'(i) ^ 8'h5A, a);
      if (!irq_n || !a) early++;
    end
    chk("R10 no flag before 68", 8'(early), 8'h00);
    i2c_byte(8'(67) ^ 8'h5A, a);
    chk("R10 flag at 68", {7'd0, irq_n}, 8'h00);
    reg_read(2'd3, d);
    chk("R10 status", d, 8'h80);
    reg_read(2'd2, d);
    chk("R10 count read", d, 8'h44);
    buf_read(67, d);
    chk("R10 last byte", d, 8'(67) ^ 8'h5A);
    clear_flag(8'hC1);
    stop_ended;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    tick(5);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    chk("R1 scl_oe", {7'd0, scl_oe}, 8'h00);
    chk("R1 sda_oe", {7'd0, sda_oe}, 8'h00);
    reg_read(2'd1, d); chk("R1 control", d, 8'h00);
    reg_read(2'd3, d); chk("R1 status", d, 8'hF8);

    // R2 R3 R4 address vectors
    reg_write(2'd2, 8'h01);
    reg_write(2'd1, 8'hC1);
    foreach (VEC[k]) begin
      reg_write(2'd0, VEC[k][24:17]);
      i2c_start;
      i2c_byte(VEC[k][16:9], a);
      chk($sformatf("R2/R3/R4 vec %0d ack", k), {7'd0, a}, {7'd0, VEC[k][8]});
      if (VEC[k][8]) begin
        chk($sformatf("R2 vec %0d irq", k), {7'd0, irq_n}, 8'h00);
        reg_read(2'd3, d);
        chk($sformatf("R3 vec %0d status", k), d, VEC[k][7:0]);
        clear_flag(8'hC1);
        stop_ended;
      end else begin
        chk($sformatf("R4 vec %0d irq", k), {7'd0, irq_n}, 8'h01);
        i2c_stop;
      end
    end
    reg_write(2'd0, 8'hAA);

    // R5 R8 buffered run of 3
    open_own(8'h03);
    i2c_byte(8'h11, a); chk("R5 b0 no flag", {6'd0, a, irq_n}, 8'h03);
    i2c_byte(8'h22, a); chk("R5 b1 no flag", {6'd0, a, irq_n}, 8'h03);
    i2c_byte(8'h33, a); chk("R5 b2 flag", {6'd0, a, irq_n}, 8'h02);
    chk("R8 stretch", {7'd0, scl_oe}, 8'h01);
    reg_read(2'd3, d); chk("R5 status", d, 8'h80);
    reg_read(2'd2, d); chk("R5 count read", d, 8'h03);
    buf_read(0, d); chk("R5 buf0", d, 8'h11);
    buf_read(1, d); chk("R5 buf1", d, 8'h22);
    buf_read(2, d); chk("R5 buf2", d, 8'h33);
    clear_flag(8'hC1); tick(3); @(negedge clk);
    chk("R8 released", {6'd0, scl_oe, irq_n}, 8'h01);
    reg_write(2'd1, 8'hC9); tick(3); @(negedge clk);
    chk("R8 write one no set", {7'd0, irq_n}, 8'h01);
    i2c_byte(8'h44, a); chk("R5 next run no flag", {6'd0, a, irq_n}, 8'h03);
    stop_ended;
    reg_read(2'd2, d); chk("R9 count after stop", d, 8'h01);
    buf_read(0, d); chk("R5 new run index0", d, 8'h44);

    // R9 repeated start
    open_own(8'h05);
    i2c_byte(8'h55, a);
    i2c_rstart; @(negedge clk);
    chk("R9 rstart irq", {7'd0, irq_n}, 8'h00);
    reg_read(2'd3, d); chk("R9 rstart status", d, 8'hA0);
    clear_flag(8'hC1);
    i2c_byte(8'hAA, a); chk("R9 readdress ack", {7'd0, a}, 8'h01);
    reg_read(2'd3, d); chk("R9 readdress status", d, 8'h60);
    clear_flag(8'hC1);
    stop_ended;

    // R7 last-byte flag
    open_own(8'h82);
    i2c_byte(8'h01, a); chk("R7 b0 ack", {6'd0, a, irq_n}, 8'h03);
    i2c_byte(8'h02, a); chk("R7 final nack", {6'd0, a, irq_n}, 8'h00);
    chk("R7 no stretch after nack", {7'd0, scl_oe}, 8'h00);
    reg_read(2'd3, d); chk("R7 status", d, 8'h88);
    clear_flag(8'hC1);
    i2c_byte(8'h03, a); chk("R7 ignored byte", {6'd0, a, irq_n}, 8'h01);
    buf_read(0, d); chk("R7 buf0 untouched", d, 8'h01);
    buf_read(1, d); chk("R7 buf1", d, 8'h02);
    i2c_stop; tick(4); @(negedge clk);
    chk("R7 stop ignored", {7'd0, irq_n}, 8'h01);
    reg_read(2'd3, d); chk("R7 status kept", d, 8'h88);

    // R7 acknowledge-enable low at final byte
    reg_write(2'd2, 8'h02);
    i2c_start;
    i2c_byte(8'hAA, a);
    clear_flag(8'h41);
    i2c_byte(8'h10, a); chk("R7 aa0 b0 ack", {7'd0, a}, 8'h01);
    i2c_byte(8'h20, a); chk("R7 aa0 final nack", {7'd0, a}, 8'h00);
    reg_read(2'd3, d); chk("R7 aa0 status", d, 8'h88);
    clear_flag(8'hC1);
    i2c_stop;

    // R3 R5 general call data
    reg_write(2'd0, 8'hAB);
    reg_write(2'd2, 8'h01);
    i2c_start;
    i2c_byte(8'h00, a);
    reg_read(2'd3, d); chk("R3 gc status", d, 8'hD0);
    clear_flag(8'hC1);
    i2c_byte(8'h5A, a); chk("R5 gc data", {6'd0, a, irq_n}, 8'h02);
    reg_read(2'd3, d); chk("R5 gc status", d, 8'h90);
    buf_read(0, d); chk("R5 gc buf0", d, 8'h5A);
    clear_flag(8'hC1);
    stop_ended;
    reg_write(2'd0, 8'hAA);

    // R6 byte mode
    reg_write(2'd1, 8'hC0);
    reg_write(2'd2, 8'h03);
    i2c_start;
    i2c_byte(8'hAA, a);
    clear_flag(8'hC0);
    i2c_byte(8'h77, a); chk("R6 byte mode flag", {6'd0, a, irq_n}, 8'h02);
    reg_read(2'd3, d); chk("R6 status", d, 8'h80);
    clear_flag(8'hC0);
    stop_ended;

    // R4 not enabled, ack disabled, start request set
    reg_write(2'd1, 8'h81);
    i2c_start; i2c_byte(8'hAA, a); i2c_stop;
    chk("R4 disabled nack", {6'd0, a, irq_n}, 8'h01);
    reg_write(2'd1, 8'h41);
    i2c_start; i2c_byte(8'hAA, a); i2c_stop;
    chk("R4 aa0 nack", {6'd0, a, irq_n}, 8'h01);
    reg_write(2'd1, 8'hE1);
    i2c_start; i2c_byte(8'hAA, a); i2c_stop;
    chk("R4 start req nack", {6'd0, a, irq_n}, 8'h01);
    reg_write(2'd1, 8'hC1);

    // R10 clamp
    clamp_run(8'h00);
    clamp_run(8'h64);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule